// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block collects level-sensitive interrupt requests from 26 system sources and from a secondary group of 32 general-purpose I/O sources. It presents them to a processor through one interrupt line. The system requests are held in two 16-bit status words. Lines 0 to 15 go to the lower word, and lines 16 to 25 go to bits 0 to 9 of the upper word. Each word has its own enable mask. The processor line is raised whenever any enabled status bit in either word is set.

The I/O group is a second level with its own 32-bit status and enable mask. When any enabled bit of that group is set, the group output is raised. The group output is also ORed into system request line 9, the cascade input, so software that enables line 9 receives I/O events through the main line. A flat register port gives access to status, mask and clear operations at fixed byte offsets. Reads are combinational, and writes take effect at the clock edge.

Because every request is level-sensitive, a status bit simply follows its line one clock later. A clear write cannot drop a bit whose line is still asserted. A bit whose line is released falls on its own.

Top module: `casc_irq_ctl`

## Requirements
- R1: System lines 0 to 15 appear in the lower status word (offset 0x80), bit n for line n, one clock edge after they are sampled.
- R2: System lines 16 to 25 appear in bits 0 to 9 of the upper status word (offset 0xA0). Bits 10 to 15 of that word always read 0.
- R3: A status bit falls at the first clock edge after its request line is released.
- R4: A write to offset 0x80 or 0xA0 clears the bits that are 1 in the data, but a bit whose line is still asserted stays 1 (set wins).
- R5: The lower mask (0x8C) and upper mask (0xA6) are 16-bit read/write registers, and the I/O mask (0x94) is a 32-bit read/write register. Each write is visible from the next edge.
- R6: `cpu_irq_o` is 1 exactly when (lower status AND lower mask) OR (upper status AND upper mask) is nonzero, evaluated on current register contents.
- R7: The I/O status word holds the 32 I/O request lines one edge after sampling. It reads at offset 0x88 and identically at offset 0x108.
- R8: `gpio_irq_o` is 1 exactly when (I/O status AND I/O mask) is nonzero.
- R9: `gpio_irq_o` is ORed into system line 9, so lower status bit 9 sets one edge after `gpio_irq_o` rises. A cascaded request therefore reaches `cpu_irq_o` two edges after the I/O line is sampled.
- R10: Reads of any offset other than the seven listed return 0. Writes to such offsets change no status or mask register.
- R11: While reset is active and after it is released, all status and mask registers read 0 and both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sys_req_i | input | 26 | Level-sensitive system interrupt requests |
| gpio_req_i | input | 32 | Level-sensitive I/O interrupt requests |
| bus_sel_i | input | 1 | Register access in this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 9 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data (combinational, 0 when not reading) |
| cpu_irq_o | output | 1 | Interrupt to the processor |
| gpio_irq_o | output | 1 | Combined I/O group interrupt |

## Verification
On every cycle, the assertions check the following:
- each status word tracks the request lines of the previous cycle, and the upper word's unused bits stay zero;
- a clear write never drops a bit whose line is still asserted;
- mask writes land, and both outputs stay quiet while their masks are zero;
- the cascade bit follows the group output;
- unmapped reads return zero.

The bench scenarios are needed for the rest: the exact OR-of-ANDs value of the processor line for mixed mask and request patterns, the two-edge latency of a cascaded request, the equality of the mirrored I/O status offset, and the evidence that writes to unmapped offsets leave every register unchanged.

// File: rtl/casc_irq_pkg.sv
package casc_irq_pkg;

  localparam int ADDR_W = 9;
  localparam int DATA_W = 32;
  localparam int REG_W  = 16;

  // Register byte offsets; software decodes these, so they are fixed.
  localparam logic [ADDR_W-1:0] OFS_STAT_LO  = 9'h080;
  localparam logic [ADDR_W-1:0] OFS_GSTAT    = 9'h088;
  localparam logic [ADDR_W-1:0] OFS_MASK_LO  = 9'h08C;
  localparam logic [ADDR_W-1:0] OFS_GMASK    = 9'h094;
  localparam logic [ADDR_W-1:0] OFS_STAT_HI  = 9'h0A0;
  localparam logic [ADDR_W-1:0] OFS_MASK_HI  = 9'h0A6;
  localparam logic [ADDR_W-1:0] OFS_GSTAT_MR = 9'h108;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT_LO,
    SEL_STAT_HI,
    SEL_MASK_LO,
    SEL_MASK_HI,
    SEL_GSTAT,
    SEL_GMASK
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] ofs);
    reg_sel_e sel;
    case (ofs)
      OFS_STAT_LO:  sel = SEL_STAT_LO;
      OFS_STAT_HI:  sel = SEL_STAT_HI;
      OFS_MASK_LO:  sel = SEL_MASK_LO;
      OFS_MASK_HI:  sel = SEL_MASK_HI;
      OFS_GSTAT,
      OFS_GSTAT_MR: sel = SEL_GSTAT;
      OFS_GMASK:    sel = SEL_GMASK;
      default:      sel = SEL_NONE;
    endcase
    return sel;
  endfunction

  // Any enabled pending bit in a word.
  function automatic logic any_enabled(input logic [DATA_W-1:0] stat,
                                       input logic [DATA_W-1:0] mask);
    return |(stat & mask);
  endfunction

endpackage

// File: rtl/irq_level_bank.sv
// Status word for level-sensitive requests: each live bit mirrors its
// line one edge later; bits at or above LIVE are tied to zero.
module irq_level_bank #(
  parameter int WIDTH = 16,
  parameter int LIVE  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] req_i,
  output logic [WIDTH-1:0] status_o
);

  logic [WIDTH-1:0] live_mask;
  logic [WIDTH-1:0] status_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_live
    if (i < LIVE) begin : g_on
      assign live_mask[i] = 1'b1;
    end else begin : g_off
      assign live_mask[i] = 1'b0;
    end
  end

  // A pending clear can never beat an asserted line, and a released
  // line already drops the bit, so the next state is the masked level.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= req_i & live_mask;
  end

  assign status_o = status_q;

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] mask_o
);

  logic [WIDTH-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (we_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/casc_irq_regs.sv
// Register port: offset decode, mask storage and read mux.
module casc_irq_regs
  import casc_irq_pkg::*;
#(
  parameter int GPIO_LINES = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  bus_sel_i,
  input  logic                  bus_we_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic [DATA_W-1:0]     bus_rdata_o,
  input  logic [REG_W-1:0]      stat_lo_i,
  input  logic [REG_W-1:0]      stat_hi_i,
  input  logic [GPIO_LINES-1:0] gstat_i,
  output logic [REG_W-1:0]      mask_lo_o,
  output logic [REG_W-1:0]      mask_hi_o,
  output logic [GPIO_LINES-1:0] gmask_o,
  output logic                  stat_lo_wr_o,
  output logic                  stat_hi_wr_o,
  output logic                  mask_lo_wr_o
);

  reg_sel_e sel;
  logic     wr, rd;
  logic     mask_hi_wr, gmask_wr;

  assign sel = decode_ofs(bus_addr_i);
  assign wr  = bus_sel_i &  bus_we_i;
  assign rd  = bus_sel_i & ~bus_we_i;

  assign stat_lo_wr_o = wr & (sel == SEL_STAT_LO);
  assign stat_hi_wr_o = wr & (sel == SEL_STAT_HI);
  assign mask_lo_wr_o = wr & (sel == SEL_MASK_LO);
  assign mask_hi_wr   = wr & (sel == SEL_MASK_HI);
  assign gmask_wr     = wr & (sel == SEL_GMASK);

  irq_mask_reg #(.WIDTH(REG_W)) u_mask_lo (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mask_lo_wr_o),
    .wdata_i(bus_wdata_i[REG_W-1:0]),
    .mask_o (mask_lo_o)
  );

  irq_mask_reg #(.WIDTH(REG_W)) u_mask_hi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mask_hi_wr),
    .wdata_i(bus_wdata_i[REG_W-1:0]),
    .mask_o (mask_hi_o)
  );

  irq_mask_reg #(.WIDTH(GPIO_LINES)) u_gmask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (gmask_wr),
    .wdata_i(bus_wdata_i[GPIO_LINES-1:0]),
    .mask_o (gmask_o)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (rd) begin
      case (sel)
        SEL_STAT_LO: bus_rdata_o = DATA_W'(stat_lo_i);
        SEL_STAT_HI: bus_rdata_o = DATA_W'(stat_hi_i);
        SEL_MASK_LO: bus_rdata_o = DATA_W'(mask_lo_o);
        SEL_MASK_HI: bus_rdata_o = DATA_W'(mask_hi_o);
        SEL_GSTAT:   bus_rdata_o = DATA_W'(gstat_i);
        SEL_GMASK:   bus_rdata_o = DATA_W'(gmask_o);
        default:     bus_rdata_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/casc_irq_ctl.sv
module casc_irq_ctl
  import casc_irq_pkg::*;
#(
  parameter int SYS_LINES    = 26,
  parameter int GPIO_LINES   = 32,
  parameter int CASCADE_LINE = 9
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [SYS_LINES-1:0]  sys_req_i,
  input  logic [GPIO_LINES-1:0] gpio_req_i,
  input  logic                  bus_sel_i,
  input  logic                  bus_we_i,
  input  logic [ADDR_W-1:0]     bus_addr_i,
  input  logic [DATA_W-1:0]     bus_wdata_i,
  output logic [DATA_W-1:0]     bus_rdata_o,
  output logic                  cpu_irq_o,
  output logic                  gpio_irq_o
);

  localparam int HI_LIVE = SYS_LINES - REG_W;

  logic [GPIO_LINES-1:0] gstat, gmask;
  logic [REG_W-1:0]      stat_lo, stat_hi, mask_lo, mask_hi;
  logic [SYS_LINES-1:0]  sys_eff;
  logic [REG_W-1:0]      req_lo, req_hi;
  logic                  stat_lo_wr, stat_hi_wr, mask_lo_wr;

  // Second level: I/O group
  irq_level_bank #(.WIDTH(GPIO_LINES), .LIVE(GPIO_LINES)) u_gbank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (gpio_req_i),
    .status_o(gstat)
  );

  assign gpio_irq_o = any_enabled(DATA_W'(gstat), DATA_W'(gmask));

  // Cascade: group output joins one system line
  assign sys_eff = sys_req_i | (SYS_LINES'(gpio_irq_o) << CASCADE_LINE);
  assign req_lo  = REG_W'(sys_eff);
  assign req_hi  = REG_W'(sys_eff >> REG_W);

  // First level: two system status words
  irq_level_bank #(.WIDTH(REG_W), .LIVE(REG_W)) u_bank_lo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_lo),
    .status_o(stat_lo)
  );

  irq_level_bank #(.WIDTH(REG_W), .LIVE(HI_LIVE)) u_bank_hi (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_hi),
    .status_o(stat_hi)
  );

  casc_irq_regs #(.GPIO_LINES(GPIO_LINES)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_sel_i   (bus_sel_i),
    .bus_we_i    (bus_we_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .stat_lo_i   (stat_lo),
    .stat_hi_i   (stat_hi),
    .gstat_i     (gstat),
    .mask_lo_o   (mask_lo),
    .mask_hi_o   (mask_hi),
    .gmask_o     (gmask),
    .stat_lo_wr_o(stat_lo_wr),
    .stat_hi_wr_o(stat_hi_wr),
    .mask_lo_wr_o(mask_lo_wr)
  );

  assign cpu_irq_o = any_enabled(DATA_W'(stat_lo), DATA_W'(mask_lo)) |
                     any_enabled(DATA_W'(stat_hi), DATA_W'(mask_hi));

endmodule

// File: rtl/casc_irq_ctl_chk.sv
module casc_irq_ctl_chk
  import casc_irq_pkg::*;
#(
  parameter int SYS_LINES    = 26,
  parameter int GPIO_LINES   = 32,
  parameter int CASCADE_LINE = 9
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  bus_sel_i,
  input logic                  bus_we_i,
  input logic [ADDR_W-1:0]     bus_addr_i,
  input logic [DATA_W-1:0]     bus_wdata_i,
  input logic [DATA_W-1:0]     bus_rdata_o,
  input logic                  cpu_irq_o,
  input logic                  gpio_irq_o,
  input logic [SYS_LINES-1:0]  sys_eff,
  input logic [REG_W-1:0]      stat_lo,
  input logic [REG_W-1:0]      stat_hi,
  input logic [REG_W-1:0]      mask_lo,
  input logic [REG_W-1:0]      mask_hi,
  input logic [GPIO_LINES-1:0] gmask,
  input logic                  stat_lo_wr
);

  localparam int HI_LIVE = SYS_LINES - REG_W;

  logic                   past_ok;
  logic [2*REG_W-1:0]     sys_all;
  logic [REG_W-1:0]       lo_req;

  assign sys_all = {stat_hi, stat_lo};
  assign lo_req  = REG_W'(sys_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  a_r1_lo_tracks_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> (stat_lo == $past(lo_req)));

  a_r2_hi_spare_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_hi >> HI_LIVE) == '0);

  a_r4_set_beats_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_lo_wr && ((bus_wdata_i[REG_W-1:0] & lo_req) != '0)) |=>
    ((stat_lo & $past(bus_wdata_i[REG_W-1:0] & lo_req)) ==
     $past(bus_wdata_i[REG_W-1:0] & lo_req)));

  a_r5_mask_lo_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && bus_we_i && bus_addr_i == OFS_MASK_LO) |=>
    (mask_lo == $past(bus_wdata_i[REG_W-1:0])));

  a_r6_cpu_quiet_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_lo == '0 && mask_hi == '0) |-> !cpu_irq_o);

  a_r8_gpio_quiet_unmasked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gmask == '0) |-> !gpio_irq_o);

  a_r9_cascade_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(gpio_irq_o)) |-> sys_all[CASCADE_LINE]);

  a_r10_unmapped_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && !bus_we_i && decode_ofs(bus_addr_i) == SEL_NONE) |->
    (bus_rdata_o == '0));

endmodule

bind casc_irq_ctl casc_irq_ctl_chk #(
  .SYS_LINES   (SYS_LINES),
  .GPIO_LINES  (GPIO_LINES),
  .CASCADE_LINE(CASCADE_LINE)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .bus_sel_i  (bus_sel_i),
  .bus_we_i   (bus_we_i),
  .bus_addr_i (bus_addr_i),
  .bus_wdata_i(bus_wdata_i),
  .bus_rdata_o(bus_rdata_o),
  .cpu_irq_o  (cpu_irq_o),
  .gpio_irq_o (gpio_irq_o),
  .sys_eff    (sys_eff),
  .stat_lo    (stat_lo),
  .stat_hi    (stat_hi),
  .mask_lo    (mask_lo),
  .mask_hi    (mask_hi),
  .gmask      (gmask),
  .stat_lo_wr (stat_lo_wr)
);

// File: tb/casc_irq_ctl_tb_top.sv
`timescale 1ns/1ps
module casc_irq_ctl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [25:0] sys_req = '0;
  logic [31:0] gpio_req = '0;
  logic        sel = 1'b0, we = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        cpu_irq, gpio_irq;

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;

  logic [15:0] m_lo = '0, m_hi = '0;
  logic [31:0] m_g  = '0;

  always #2.5 clk = ~clk;

  casc_irq_ctl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sys_req_i(sys_req), .gpio_req_i(gpio_req),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .cpu_irq_o(cpu_irq), .gpio_irq_o(gpio_irq)
  );

  // ---- reference model (steady state, inputs held two edges) ----
  function automatic logic exp_gpio(input logic [31:0] g, input logic [31:0] gm);
    logic hit = 1'b0;
    for (int i = 0; i < 32; i++) if (g[i] && gm[i]) hit = 1'b1;
    return hit;
  endfunction

  function automatic logic [25:0] exp_lines(input logic [25:0] s, input logic [31:0] g,
                                           input logic [31:0] gm);
    logic [25:0] r = s;
    if (exp_gpio(g, gm)) r[9] = 1'b1;
    return r;
  endfunction

  function automatic logic exp_cpu(input logic [25:0] lines, input logic [15:0] ml,
                                   input logic [15:0] mh);
    logic hit = 1'b0;
    for (int i = 0; i < 26; i++) begin
      if (i < 16) begin if (lines[i] && ml[i]) hit = 1'b1; end
      else        begin if (lines[i] && mh[i-16]) hit = 1'b1; end
    end
    return hit;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    #1;
    d = rdata;
    sel = 1'b0;
  endtask

  task automatic check_all(input string tag);
    logic [25:0] l;
    logic [31:0] v;
    l = exp_lines(sys_req, gpio_req, m_g);
    bus_read(9'h080, v); check({tag, " R1 lo"}, v, {16'h0, l[15:0]});
    bus_read(9'h0A0, v); check({tag, " R2 hi"}, v, {22'h0, l[25:16]});
    bus_read(9'h088, v); check({tag, " R7 gstat"}, v, gpio_req);
    check({tag, " R8 gpio_irq"}, {31'h0, gpio_irq}, {31'h0, exp_gpio(gpio_req, m_g)});
    check({tag, " R6 cpu_irq"}, {31'h0, cpu_irq}, {31'h0, exp_cpu(l, m_lo, m_hi)});
  endtask

  initial begin
    logic [31:0] v;
    // R11: reset state
    tick(3);
    bus_read(9'h080, v); check("R11 lo in reset", v, 32'h0);
    rst_n = 1'b1;
    tick(1);
    bus_read(9'h0A0, v); check("R11 hi", v, 32'h0);
    bus_read(9'h08C, v); check("R11 mask lo", v, 32'h0);
    bus_read(9'h094, v); check("R11 gmask", v, 32'h0);
    check("R11 outputs", {30'h0, cpu_irq, gpio_irq}, 32'h0);

    // R1 / R2
    sys_req = 26'h0008008; tick(1);
    bus_read(9'h080, v); check("R1 lines 3,15", v, 32'h8008);
    sys_req = 26'h2010000; tick(1);
    bus_read(9'h0A0, v); check("R2 lines 16,25", v, 32'h0201);
    sys_req = '1; tick(1);
    bus_read(9'h0A0, v); check("R2 spare bits zero", v, 32'h03FF);
    // R3
    sys_req = '0; tick(1);
    bus_read(9'h080, v); check("R3 falls on release", v, 32'h0);
    // R4
    sys_req = 26'h0000004; tick(1);
    bus_write(9'h080, 32'hFFFF);
    bus_read(9'h080, v); check("R4 set wins lo", v, 32'h0004);
    sys_req = 26'h0020000; tick(1);
    bus_write(9'h0A0, 32'hFFFF);
    bus_read(9'h0A0, v); check("R4 set wins hi", v, 32'h0002);
    sys_req = '0; tick(1);
    bus_write(9'h080, 32'h0004);
    bus_read(9'h080, v); check("R4 cleared", v, 32'h0);
    // R5
    bus_write(9'h08C, 32'hABCD_1234); m_lo = 16'h1234;
    bus_read(9'h08C, v); check("R5 mask lo", v, 32'h1234);
    bus_write(9'h0A6, 32'h0000_5A5A); m_hi = 16'h5A5A;
    bus_read(9'h0A6, v); check("R5 mask hi", v, 32'h5A5A);
    bus_write(9'h094, 32'hDEAD_BEEF); m_g = 32'hDEAD_BEEF;
    bus_read(9'h094, v); check("R5 gmask", v, 32'hDEAD_BEEF);
    // R6
    sys_req = 26'h0000004; tick(1);
    check("R6 masked bit 2 raises", {31'h0, cpu_irq}, 32'h1);
    sys_req = 26'h0000001; tick(1);
    check("R6 unmasked bit 0 quiet", {31'h0, cpu_irq}, 32'h0);
    sys_req = 26'h0020000; tick(1);
    check("R6 hi bit 1 via mask hi", {31'h0, cpu_irq}, 32'h1);
    sys_req = '0;
    // R7 mirror
    gpio_req = 32'h8000_0001; tick(1);
    bus_read(9'h108, v); check("R7 mirror", v, 32'h8000_0001);
    check("R8 gpio_irq", {31'h0, gpio_irq}, 32'h1);
    gpio_req = 32'h0000_0010; tick(2);
    check("R8 gpio masked off", {31'h0, gpio_irq}, 32'h0);
    // R9 cascade latency
    gpio_req = '0; bus_write(9'h08C, 32'h0200); m_lo = 16'h0200; tick(2);
    gpio_req = 32'h0000_0001; tick(1);
    check("R9 gpio_irq after 1 edge", {31'h0, gpio_irq}, 32'h1);
    check("R9 cpu_irq not yet", {31'h0, cpu_irq}, 32'h0);
    tick(1);
    check("R9 cpu_irq after 2 edges", {31'h0, cpu_irq}, 32'h1);
    bus_read(9'h080, v); check("R9 lo bit 9", v, 32'h0200);
    // R10
    bus_write(9'h084, 32'hFFFF_FFFF);
    bus_write(9'h08E, 32'hFFFF_FFFF);
    bus_write(9'h1FE, 32'hFFFF_FFFF);
    bus_read(9'h084, v); check("R10 unmapped read", v, 32'h0);
    bus_read(9'h1FC, v); check("R10 unmapped read high", v, 32'h0);
    bus_read(9'h08C, v); check("R10 mask lo kept", v, 32'h0200);
    bus_read(9'h0A6, v); check("R10 mask hi kept", v, 32'h5A5A);
    bus_read(9'h094, v); check("R10 gmask kept", v, 32'hDEAD_BEEF);
    check_all("R10 status kept");

    // Random mixed traffic
    void'($urandom(32'h1F2E3D));
    for (int it = 0; it < 300; it++) begin
      if (($urandom() & 3) == 0) begin
        m_lo = 16'($urandom()); bus_write(9'h08C, {16'h0, m_lo});
      end
      if (($urandom() & 3) == 0) begin
        m_hi = 16'($urandom()); bus_write(9'h0A6, {16'h0, m_hi});
      end
      if (($urandom() & 3) == 0) begin
        m_g = $urandom() & $urandom(); bus_write(9'h094, m_g);
      end
      sys_req  = 26'($urandom() & $urandom() & $urandom());
      gpio_req = $urandom() & $urandom() & $urandom();
      tick(2);
      check_all("rand");
    end

    finished = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule